// File: doc/BRIEF.md
# Cascadable Banded Address Decoder

This block turns a pair of addresses into a run of select lines. When it is enabled, every output line whose index lies between a lower address and an upper address, both ends included, is driven high. All other lines stay low. A memory array can use it to select a rectangle of cells, with one decoder for the rows and one for the columns. Every cell where a selected row crosses a selected column is then written in a single cycle.

The decoder is built from two halves, and their results are ANDed. The lower half turns the lower address into a one-hot code and spreads the hot bit upward, so it marks every line at or above that address. The upper half does the same with the upper address and spreads downward, so it marks every line at or below it. A parameter chooses how the spreading is done: a ripple chain with linear depth, or a parallel-prefix OR tree with logarithmic depth. Both give the same result.

Decoders can be tiled to cover a wider address space. A parent decoder drives a tile's select input from its own output for that tile. The parent outputs of the neighbouring tiles drive the two carry inputs. A carry from the tile below means the band started further down, so the lower half is forced fully on. A carry from the tile above means the band continues upward, so the upper half is forced fully on. A strobe gates every output. The result is registered, so it appears one clock after the inputs are presented.

Top module: `banded_range_decoder`

## Requirements
- R1: With strobe=1, sel=1 and both carries 0, output line i is 1 exactly when lo_addr <= i <= hi_addr, one clock after the inputs are presented.
- R2: With strobe=1, sel=1, both carries 0 and lo_addr > hi_addr, every output line is 0.
- R3: With strobe=1, sel=1, both carries 0 and lo_addr == hi_addr, exactly one line is 1: the line at that index.
- R4: With carry_below=1 and carry_above=0 (strobe=1, sel=1), lo_addr has no effect and lines 0 through hi_addr are 1.
- R5: With carry_above=1 and carry_below=0 (strobe=1, sel=1), hi_addr has no effect and lines lo_addr through the top line are 1.
- R6: With both carries 1 (strobe=1, sel=1), every output line is 1, whatever the addresses.
- R7: With sel=0, every output line is 0, whatever the addresses, carries and strobe.
- R8: With strobe=0, every output line is 0, whatever the addresses, carries and select.
- R9: The output is registered. A change at the inputs reaches the lines at the first rising clock edge after it, and not before.
- R10: While reset is asserted, and until the first edge after its synchronised release, every output line is 0.
- R11: The chain build (SPREAD_IMPL=0) and the prefix-tree build (SPREAD_IMPL=1) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strobe | input | 1 | Output gate; 0 forces all lines low |
| sel | input | 1 | Tile select from the parent decoder |
| carry_below | input | 1 | The band continues from the tile below; forces the lower half fully on |
| carry_above | input | 1 | The band continues into the tile above; forces the upper half fully on |
| lo_addr | input | AW | Lower band address, inclusive |
| hi_addr | input | AW | Upper band address, inclusive |
| lines | output | 2**AW | Registered band select lines |

## Verification
The bench sweeps every pair of lower and upper addresses under all four carry settings. It runs the chain build and the tree build side by side and compares each against a band worked out arithmetically. This sweep exposes an off-by-one at either end of the band: a design with that fault drops line lo_addr or line hi_addr, or adds the line just past either one. It also exposes a design that lights lines when the addresses are reversed, because such a design leaks its wrapped spread bits. A carry fed in at the wrong end of a chain, or into the wrong half, shows up as a band that is cut short at the tile boundary or runs the wrong way. Further sweeps hold sel or strobe low to find any path that bypasses the gate. A timing check catches an output that is left combinational, because such an output changes before the clock edge.

// File: rtl/banded_decoder_pkg.sv
package banded_decoder_pkg;
  typedef enum logic {
    SPREAD_CHAIN = 1'b0,
    SPREAD_TREE  = 1'b1
  } spread_impl_e;
endpackage

// File: rtl/band_onehot.sv
module band_onehot #(
  parameter int AW = 6,
  localparam int N = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hot
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot[i] = (addr == AW'(i));
  end
endmodule

// File: rtl/band_spread.sv
// Spreads every set input bit toward the high end of the vector, or toward
// the low end when UPWARD is 0. A seed bit turns the whole vector on.
module band_spread #(
  parameter int N = 64,
  parameter banded_decoder_pkg::spread_impl_e IMPL = banded_decoder_pkg::SPREAD_CHAIN,
  parameter bit UPWARD = 1'b1,
  localparam int LVL = $clog2(N)
) (
  input  logic [N-1:0] vin,
  input  logic         seed,
  output logic [N-1:0] therm
);
  logic [N-1:0] oriented;
  logic [N-1:0] spread;

  // Reverse the vector for the downward case, so that one upward core serves both.
  for (genvar i = 0; i < N; i++) begin : g_orient
    if (UPWARD) begin : g_up
      assign oriented[i] = vin[i];
      assign therm[i]    = spread[i];
    end else begin : g_dn
      assign oriented[i] = vin[N-1-i];
      assign therm[i]    = spread[N-1-i];
    end
  end

  if (IMPL == banded_decoder_pkg::SPREAD_CHAIN) begin : g_chain
    // Ripple chain: the seed enters at the base and each stage ORs in its neighbour.
    logic [N-1:0] link;
    assign link[0] = oriented[0] | seed;
    for (genvar i = 1; i < N; i++) begin : g_link
      assign link[i] = oriented[i] | link[i-1];
    end
    assign spread = link;
  end else begin : g_tree
    // Prefix OR tree: log2(N) levels, each doubling the reach of the previous one.
    logic [N-1:0] stage [LVL+1];
    assign stage[0] = oriented;
    for (genvar k = 0; k < LVL; k++) begin : g_lvl
      for (genvar i = 0; i < N; i++) begin : g_bit
        if (i >= (1 << k)) begin : g_or
          assign stage[k+1][i] = stage[k][i] | stage[k][i-(1<<k)];
        end else begin : g_pass
          assign stage[k+1][i] = stage[k][i];
        end
      end
    end
    assign spread = stage[LVL] | {N{seed}};
  end
endmodule

// File: rtl/band_reset_sync.sv
module band_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_q_n = sync_q;
endmodule

// File: rtl/banded_range_decoder.sv
module banded_range_decoder #(
  parameter int AW = 6,
  parameter banded_decoder_pkg::spread_impl_e SPREAD_IMPL = banded_decoder_pkg::SPREAD_CHAIN,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          sel,
  input  logic          carry_below,
  input  logic          carry_above,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  output logic [N-1:0]  lines
);
  logic         rst_q_n;
  logic [N-1:0] lo_hot;
  logic [N-1:0] hi_hot;
  logic [N-1:0] at_or_above;
  logic [N-1:0] at_or_below;
  logic [N-1:0] lines_d;
  logic [N-1:0] lines_q;
  logic         lines_en;

  band_reset_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  band_onehot #(.AW(AW)) u_lo_dec (.addr(lo_addr), .hot(lo_hot));
  band_onehot #(.AW(AW)) u_hi_dec (.addr(hi_addr), .hot(hi_hot));

  band_spread #(.N(N), .IMPL(SPREAD_IMPL), .UPWARD(1'b1)) u_lo_spread (
    .vin   (lo_hot),
    .seed  (carry_below),
    .therm (at_or_above)
  );

  band_spread #(.N(N), .IMPL(SPREAD_IMPL), .UPWARD(1'b0)) u_hi_spread (
    .vin   (hi_hot),
    .seed  (carry_above),
    .therm (at_or_below)
  );

  // Next state: the two halves intersected, then gated by select and strobe.
  assign lines_en = 1'b1;
  always_comb begin
    lines_d = '0;
    if (strobe && sel) begin
      lines_d = at_or_above & at_or_below;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lines_q <= '0;
    end else if (lines_en) begin
      lines_q <= lines_d;
    end
  end

  assign lines = lines_q;
endmodule

// File: rtl/banded_range_decoder_chk.sv
module banded_range_decoder_chk #(
  parameter int AW = 6,
  localparam int N = 1 << AW
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          strobe,
  input logic          sel,
  input logic          carry_below,
  input logic          carry_above,
  input logic [AW-1:0] lo_addr,
  input logic [AW-1:0] hi_addr,
  input logic [N-1:0]  lines
);
  assert_band_ends_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && sel && !carry_below && !carry_above && lo_addr <= hi_addr)
    |=> (lines[$past(lo_addr)] && lines[$past(hi_addr)]));

  assert_reversed_empty_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && sel && !carry_below && !carry_above && lo_addr > hi_addr)
    |=> (lines == '0));

  assert_single_line_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && sel && !carry_below && !carry_above && lo_addr == hi_addr)
    |=> ($countones(lines) == 1));

  assert_below_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && sel && carry_below && !carry_above)
    |=> (lines[0] && lines[$past(hi_addr)]));

  assert_above_to_top_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && sel && !carry_below && carry_above)
    |=> (lines[N-1] && lines[$past(lo_addr)]));

  assert_both_carries_full_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (strobe && sel && carry_below && carry_above) |=> (&lines));

  assert_deselected_quiet_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sel |=> (lines == '0));

  assert_unstrobed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !strobe |=> (lines == '0));
endmodule

bind banded_range_decoder banded_range_decoder_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .strobe      (strobe),
  .sel         (sel),
  .carry_below (carry_below),
  .carry_above (carry_above),
  .lo_addr     (lo_addr),
  .hi_addr     (hi_addr),
  .lines       (lines)
);

// File: tb/banded_range_decoder_tb.sv
module banded_range_decoder_tb;
  localparam int AW = 6;
  localparam int N = 1 << AW;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 150000;

  logic          clk;
  logic          rst_n;
  logic          strobe;
  logic          sel;
  logic          carry_below;
  logic          carry_above;
  logic [AW-1:0] lo_addr;
  logic [AW-1:0] hi_addr;
  logic [N-1:0]  lines_chain;
  logic [N-1:0]  lines_tree;

  int  n_checks;
  int  n_fails;
  bit  done;

  banded_range_decoder #(.AW(AW), .SPREAD_IMPL(banded_decoder_pkg::SPREAD_CHAIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel(sel),
    .carry_below(carry_below), .carry_above(carry_above),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .lines(lines_chain)
  );

  banded_range_decoder #(.AW(AW), .SPREAD_IMPL(banded_decoder_pkg::SPREAD_TREE)) u_dut_tree (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel(sel),
    .carry_below(carry_below), .carry_above(carry_above),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .lines(lines_tree)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [N-1:0] band_model(input logic st, input logic sl,
                                              input logic cb, input logic ca,
                                              input int lo, input int hi);
    logic [N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) begin
      v[i] = st && sl && (cb || i >= lo) && (ca || i <= hi);
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: lo=%0d hi=%0d st=%0b sel=%0b cb=%0b ca=%0b actual=%h expected=%h",
               tag, lo_addr, hi_addr, strobe, sel, carry_below, carry_above, act, exp);
    end
  endtask

  function automatic string tag_for(input logic st, input logic sl, input logic cb,
                                    input logic ca, input int lo, input int hi);
    if (!st) return "R8";
    if (!sl) return "R7";
    if (cb && ca) return "R6";
    if (cb) return "R4";
    if (ca) return "R5";
    if (lo > hi) return "R2";
    if (lo == hi) return "R3";
    return "R1";
  endfunction

  // Drive on a falling edge, let one rising edge register it, sample on the next falling edge.
  task automatic apply(input logic st, input logic sl, input logic cb, input logic ca,
                       input int lo, input int hi);
    logic [N-1:0] exp;
    @(negedge clk);
    strobe = st; sel = sl; carry_below = cb; carry_above = ca;
    lo_addr = AW'(lo); hi_addr = AW'(hi);
    @(negedge clk);
    exp = band_model(st, sl, cb, ca, lo, hi);
    check(tag_for(st, sl, cb, ca, lo, hi), lines_chain, exp);
    check("R11", lines_tree, exp);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0;
    strobe = 1'b1; sel = 1'b1; carry_below = 1'b1; carry_above = 1'b1;
    lo_addr = '0; hi_addr = '1;
    repeat (3) @(negedge clk);
    check("R10", lines_chain, '0);
    check("R10", lines_tree, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10", lines_chain, '0);
    repeat (4) @(negedge clk);

    // R9: a new input must not show before the rising edge, and must show after it.
    apply(1'b1, 1'b1, 1'b0, 1'b0, 5, 9);
    @(negedge clk);
    lo_addr = AW'(20); hi_addr = AW'(30);
    #1;
    check("R9", lines_chain, band_model(1'b1, 1'b1, 1'b0, 1'b0, 5, 9));
    @(negedge clk);
    check("R9", lines_chain, band_model(1'b1, 1'b1, 1'b0, 1'b0, 20, 30));

    // Exhaustive address pairs under every carry setting (R1-R6, R11).
    for (int c = 0; c < 4; c++) begin
      for (int lo = 0; lo < N; lo++) begin
        for (int hi = 0; hi < N; hi++) begin
          apply(1'b1, 1'b1, c[0], c[1], lo, hi);
        end
      end
    end

    // Gating sweeps: select low (R7), strobe low (R8), and both low.
    for (int c = 0; c < 4; c++) begin
      for (int lo = 0; lo < N; lo += 3) begin
        for (int hi = 0; hi < N; hi += 5) begin
          apply(1'b1, 1'b0, c[0], c[1], lo, hi);
          apply(1'b0, 1'b1, c[0], c[1], lo, hi);
          apply(1'b0, 1'b0, c[0], c[1], lo, hi);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < WATCHDOG_CYCLES; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule